// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer Base

This block is a programmable time base. A prescaler divides the system clock. Each prescaler tick steps a counter, which can count upward, downward, or first up and then down in a triangle. When the counter reaches the end of its range, the block raises an update event. The update event drives a one-cycle pulse output and a sticky flag. The flag can also raise an interrupt request.

Software uses a simple synchronous write port and a combinational read port. Through them it can access the counter, the division ratio and the period at any time, including while the counter is running.

The period register has two stages: a preload stage and an active stage. A preload-enable bit selects when a new period takes effect: at once, or only at the next update event. The division ratio is always double-buffered in the same way. Software can also force an update event. A forced update restarts the count and moves the buffered values into their active stages.

Top module: `ptb_timer`

Register map (3-bit address, 16-bit data):

| Address | Name | Contents |
|---|---|---|
| 0 | control | bit0 count enable; bits 2:1 mode (0 up, 1 down, 2 up/down, 3 behaves as up); bit3 preload enable; bit4 interrupt enable |
| 1 | counter | the counter value |
| 2 | prescaler | preload stage of the prescaler |
| 3 | period | preload stage of the period |
| 4 | flag | bit0 is the update flag; writing 1 clears it |
| 5 | event | writing 1 to bit0 forces an update event; reads return 0 |

## Requirements
- R1: After reset, the registers hold the following values. Control is 0, counter is 0, prescaler is 0, period is 0xFFFF and flag is 0. Both updPulse and irq are low.
- R2: In up mode (mode 0) with period A, the counter steps 0,1,…,A. It then wraps to 0 with an update event. Update pulses are spaced (A+1)(P+1) cycles apart.
- R3: With an active prescaler value P, the counter steps once every P+1 clock cycles.
- R4: In down mode (mode 1), the counter steps downward from A to 0. It then reloads A with an update event. Updates are spaced (A+1)(P+1) cycles apart.
- R5: In up/down mode (mode 2), the counter runs 0…A and back down to 0. It reverses direction at A and at 0, with an update at each turning point. Updates are spaced A(P+1) cycles apart.
- R6: While preload enable (control bit3) is 1, a period write only changes the preload stage. The value read back is the new value. The running count uses the old period until the next update event.
- R7: While preload enable is 0, a period write takes effect in the next cycle.
- R8: A prescaler write only changes the preload stage. The ratio in use changes only at the next update event.
- R9: Writing 1 to bit0 of the event register forces an update event. This loads the active stages from the preload stages and clears the prescaler count. It reinitialises the counter to 0 in up and up/down modes, and to the preloaded period in down mode.
- R10: updPulse is high for the one cycle after each update event. In that cycle, the counter already shows its new value.
- R11: An update sets the flag. The flag stays set until software writes 1 to flag bit0; writing 0 has no effect. If an update and a clear land in the same cycle, the flag ends set. irq is the flag ANDed with control bit4.
- R12: A counter write overrides counting in its cycle. If that cycle would have wrapped, the write suppresses the update event.
- R13: While count enable is 0, the counter and prescaler hold their values and no update occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 16 | Combinational read data |
| updPulse | output | 1 | One-cycle update pulse |
| irq | output | 1 | Interrupt request |

## Verification
Two collisions can fall in the same clock cycle. In the first, an update event and a software clear of the flag coincide. In the second, an overflow and a software write of the counter coincide. The bench forces an update with the prescaler at 1:1, so the exact cycle of the next wrap is known. It then times a flag clear or a counter write to land on the edge of that wrap. It judges the result at the ports. The flag must remain set. A written counter must take the written value, produce no pulse and leave the flag clear. The counting that follows must wrap normally.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL   = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_COUNT  = 3'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_PRESC  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_PERIOD = 3'd3;
  localparam logic [REG_ADDR_W-1:0] ADDR_FLAG   = 3'd4;
  localparam logic [REG_ADDR_W-1:0] ADDR_EVENT  = 3'd5;

  typedef enum logic [1:0] {
    MODE_UP     = 2'd0,
    MODE_DOWN   = 2'd1,
    MODE_CENTER = 2'd2,
    MODE_UP_ALT = 2'd3
  } count_mode_e;

  typedef struct packed {
    logic        enable;
    count_mode_e mode;
    logic        preloadEn;
  } timer_cfg_t;

  typedef struct packed {
    logic cntWr;
    logic pscWr;
    logic perWr;
    logic forceUpd;
  } tb_strobe_t;
endpackage

// File: rtl/ptb_ctrl.sv
module ptb_ctrl
  import ptb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [4:0]            wrLow,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0]     cntVal,
  input  logic [DATA_W-1:0]     pscPre,
  input  logic [DATA_W-1:0]     perPre,
  input  logic                  updEvt,
  output timer_cfg_t            cfg,
  output tb_strobe_t            strb,
  output logic [DATA_W-1:0]     rdData,
  output logic                  irq
);
  logic irqEn;
  logic flagQ;
  logic flagClr;
  logic ctrlWr;

  assign ctrlWr        = wrEn && (wrAddr == ADDR_CTRL);
  assign flagClr       = wrEn && (wrAddr == ADDR_FLAG) && wrLow[0];
  assign strb.cntWr    = wrEn && (wrAddr == ADDR_COUNT);
  assign strb.pscWr    = wrEn && (wrAddr == ADDR_PRESC);
  assign strb.perWr    = wrEn && (wrAddr == ADDR_PERIOD);
  assign strb.forceUpd = wrEn && (wrAddr == ADDR_EVENT) && wrLow[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg   <= '{enable: 1'b0, mode: MODE_UP, preloadEn: 1'b0};
      irqEn <= 1'b0;
    end else if (ctrlWr) begin
      cfg   <= '{enable: wrLow[0], mode: count_mode_e'(wrLow[2:1]), preloadEn: wrLow[3]};
      irqEn <= wrLow[4];
    end
  end

  // set has priority over a software clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)        flagQ <= 1'b0;
    else if (updEvt)  flagQ <= 1'b1;
    else if (flagClr) flagQ <= 1'b0;
  end

  assign irq = flagQ && irqEn;

  always_comb begin
    case (rdAddr)
      ADDR_CTRL:   rdData = DATA_W'({irqEn, cfg.preloadEn, cfg.mode, cfg.enable});
      ADDR_COUNT:  rdData = cntVal;
      ADDR_PRESC:  rdData = pscPre;
      ADDR_PERIOD: rdData = perPre;
      ADDR_FLAG:   rdData = DATA_W'(flagQ);
      default:     rdData = '0;
    endcase
  end

  assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rstN)
    updEvt |=> flagQ);
  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flagClr && !updEvt) |=> !flagQ);
endmodule

// File: rtl/ptb_datapath.sv
module ptb_datapath
  import ptb_pkg::*;
#(
  parameter int               CNT_W        = 16,
  parameter int               PSC_W        = 16,
  parameter int               DATA_W       = 16,
  parameter logic [CNT_W-1:0] RESET_PERIOD = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  timer_cfg_t        cfg,
  input  tb_strobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  cntQ,
  output logic [PSC_W-1:0]  pscPreQ,
  output logic [CNT_W-1:0]  perPreQ,
  output logic              updEvt,
  output logic              updPulse
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PSC_W-1:0] PSC_ONE = PSC_W'(1);

  logic [PSC_W-1:0] pscCnt;
  logic [PSC_W-1:0] pscActive;
  logic [CNT_W-1:0] perActive;
  logic             dirDown;
  logic             tick;
  logic             wrapEvt;
  logic [CNT_W-1:0] cntNext;
  logic             dirNext;

  assign tick = cfg.enable && (pscCnt == pscActive);

  always_comb begin
    wrapEvt = 1'b0;
    cntNext = cntQ;
    dirNext = dirDown;
    if (tick) begin
      case (cfg.mode)
        MODE_DOWN: begin
          if (cntQ == '0) begin
            wrapEvt = 1'b1;
            cntNext = perActive;
          end else begin
            cntNext = cntQ - CNT_ONE;
          end
        end
        MODE_CENTER: begin
          if (!dirDown) begin
            if (cntQ >= perActive) begin
              wrapEvt = 1'b1;
              dirNext = 1'b1;
              cntNext = (perActive == '0) ? '0 : perActive - CNT_ONE;
            end else begin
              cntNext = cntQ + CNT_ONE;
            end
          end else begin
            if (cntQ == '0) begin
              wrapEvt = 1'b1;
              dirNext = 1'b0;
              cntNext = (perActive == '0) ? '0 : CNT_ONE;
            end else begin
              cntNext = cntQ - CNT_ONE;
            end
          end
        end
        default: begin
          if (cntQ >= perActive) begin
            wrapEvt = 1'b1;
            cntNext = '0;
          end else begin
            cntNext = cntQ + CNT_ONE;
          end
        end
      endcase
    end
  end

  assign updEvt = strb.forceUpd || (wrapEvt && !strb.cntWr);

  // counter and direction: force > software write > counting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      dirDown <= 1'b0;
    end else if (strb.forceUpd) begin
      cntQ    <= (cfg.mode == MODE_DOWN) ? perPreQ : '0;
      dirDown <= 1'b0;
    end else if (strb.cntWr) begin
      cntQ    <= wrData[CNT_W-1:0];
    end else begin
      cntQ    <= cntNext;
      dirDown <= dirNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             pscCnt <= '0;
    else if (updEvt)       pscCnt <= '0;
    else if (tick)         pscCnt <= '0;
    else if (cfg.enable)   pscCnt <= pscCnt + PSC_ONE;
  end

  // preload and active stages
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscPreQ   <= '0;
      pscActive <= '0;
      perPreQ   <= RESET_PERIOD;
      perActive <= RESET_PERIOD;
    end else begin
      if (strb.pscWr) pscPreQ <= wrData[PSC_W-1:0];
      if (strb.perWr) perPreQ <= wrData[CNT_W-1:0];
      if (updEvt)     pscActive <= pscPreQ;
      if (strb.perWr && !cfg.preloadEn) perActive <= wrData[CNT_W-1:0];
      else if (updEvt)                  perActive <= perPreQ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) updPulse <= 1'b0;
    else       updPulse <= updEvt;
  end

  assert_hold_disabled_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.enable && !strb.cntWr && !strb.forceUpd) |=> $stable(cntQ));
  assert_psc_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    pscCnt <= pscActive);
  assert_force_reinit_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.forceUpd && cfg.mode == MODE_UP) |=> (cntQ == '0 && pscCnt == '0 && updPulse));
  assert_direct_period_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.perWr && !cfg.preloadEn) |=> (perActive == $past(wrData[CNT_W-1:0])));
  assert_cnt_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntWr && !strb.forceUpd) |=> (cntQ == $past(wrData[CNT_W-1:0]) && !updPulse));
endmodule

// File: rtl/ptb_timer.sv
module ptb_timer
  import ptb_pkg::*;
#(
  parameter int               CNT_W        = 16,
  parameter int               PSC_W        = 16,
  parameter logic [CNT_W-1:0] RESET_PERIOD = '1,
  localparam int              DATA_W       = (CNT_W > PSC_W) ? CNT_W : PSC_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [REG_ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [REG_ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic                  updPulse,
  output logic                  irq
);
  timer_cfg_t       cfg;
  tb_strobe_t       strb;
  logic [CNT_W-1:0] cntQ;
  logic [PSC_W-1:0] pscPreQ;
  logic [CNT_W-1:0] perPreQ;
  logic             updEvt;

  ptb_ctrl #(.DATA_W(DATA_W)) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrLow  (wrData[4:0]),
    .rdAddr (rdAddr),
    .cntVal (DATA_W'(cntQ)),
    .pscPre (DATA_W'(pscPreQ)),
    .perPre (DATA_W'(perPreQ)),
    .updEvt (updEvt),
    .cfg    (cfg),
    .strb   (strb),
    .rdData (rdData),
    .irq    (irq)
  );

  ptb_datapath #(
    .CNT_W       (CNT_W),
    .PSC_W       (PSC_W),
    .DATA_W      (DATA_W),
    .RESET_PERIOD(RESET_PERIOD)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfg),
    .strb    (strb),
    .wrData  (wrData),
    .cntQ    (cntQ),
    .pscPreQ (pscPreQ),
    .perPreQ (perPreQ),
    .updEvt  (updEvt),
    .updPulse(updPulse)
  );
endmodule

// File: tb/sim_ptb_timer.sv
`timescale 1ns/1ps
module sim_ptb_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        updPulse;
  logic        irq;

  int checks = 0;
  int errors = 0;

  localparam int A_CTRL = 0, A_CNT = 1, A_PSC = 2, A_PER = 3, A_FLAG = 4, A_EVT = 5;

  always #2 clk = ~clk;

  ptb_timer u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .updPulse(updPulse), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; write lands on the next posedge; returns at the following negedge
  task automatic wr(input int addr, input int data);
    wrEn = 1'b1; wrAddr = 3'(addr); wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int addr, output int v);
    rdAddr = 3'(addr);
    #1;
    v = int'(rdData);
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!updPulse && n < 1000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v);   chk("R1 ctrl", v, 0);
    rd(A_CNT, v);    chk("R1 count", v, 0);
    rd(A_PSC, v);    chk("R1 presc", v, 0);
    rd(A_PER, v);    chk("R1 period", v, 16'hFFFF);
    rd(A_FLAG, v);   chk("R1 flag", v, 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 pulse", int'(updPulse), 0);

    // R2 R3 R4 R5 sweep of intervals between update pulses
    for (int m = 0; m < 3; m++) begin
      for (int p = 0; p < 4; p++) begin
        for (int a = 1; a < 5; a++) begin
          int expGap;
          wr(A_CTRL, m << 1);
          wr(A_PSC, p);
          wr(A_PER, a);
          wr(A_EVT, 1);
          wr(A_FLAG, 1);
          wr(A_CTRL, (m << 1) | 1);
          expGap = (m == 2) ? a * (p + 1) : (a + 1) * (p + 1);
          gap(n);
          gap(n);
          chk(m == 0 ? "R2 R3 up gap" : (m == 1 ? "R4 R3 down gap" : "R5 R3 updown gap"), n, expGap);
          gap(n);
          chk(m == 0 ? "R2 R3 up gap" : (m == 1 ? "R4 R3 down gap" : "R5 R3 updown gap"), n, expGap);
        end
      end
    end

    // R5 up/down value sequence, R9 reinit
    wr(A_CTRL, 4); wr(A_PSC, 0); wr(A_PER, 3); wr(A_CTRL, 5);
    wr(A_EVT, 1);
    begin
      int seqC[8] = '{0, 1, 2, 3, 2, 1, 0, 1};
      for (int i = 0; i < 8; i++) begin
        rd(A_CNT, v); chk("R5 updown value", v, seqC[i]);
        @(negedge clk);
      end
    end

    // R4 down value sequence after force
    wr(A_CTRL, 2); wr(A_CTRL, 3);
    wr(A_EVT, 1);
    begin
      int seqD[6] = '{3, 2, 1, 0, 3, 2};
      for (int i = 0; i < 6; i++) begin
        rd(A_CNT, v); chk("R4 down value", v, seqD[i]);
        @(negedge clk);
      end
    end

    // R6 preload enabled: period change deferred to update
    wr(A_CTRL, 8); wr(A_PSC, 0); wr(A_PER, 4); wr(A_EVT, 1);
    wr(A_PER, 1);
    rd(A_PER, v); chk("R6 period readback", v, 1);
    wr(A_CNT, 2);
    wr(A_CTRL, 9);
    begin
      int seqP[7] = '{2, 3, 4, 0, 1, 0, 1};
      for (int i = 0; i < 7; i++) begin
        rd(A_CNT, v); chk("R6 deferred period", v, seqP[i]);
        @(negedge clk);
      end
    end

    // R7 preload disabled: period change immediate
    wr(A_CTRL, 0); wr(A_PER, 4); wr(A_EVT, 1);
    wr(A_PER, 1);
    wr(A_CNT, 2);
    wr(A_CTRL, 1);
    begin
      int seqI[4] = '{2, 0, 1, 0};
      for (int i = 0; i < 4; i++) begin
        rd(A_CNT, v); chk("R7 immediate period", v, seqI[i]);
        @(negedge clk);
      end
    end

    // R8 prescaler buffered until update
    wr(A_CTRL, 0); wr(A_PSC, 0); wr(A_PER, 10); wr(A_EVT, 1);
    wr(A_PSC, 3);
    rd(A_PSC, v); chk("R8 presc readback", v, 3);
    wr(A_CNT, 0);
    wr(A_CTRL, 1);
    for (int i = 0; i < 3; i++) begin
      rd(A_CNT, v); chk("R8 old ratio", v, i);
      @(negedge clk);
    end
    wr(A_EVT, 1);
    begin
      int seqS[5] = '{0, 0, 0, 0, 1};
      for (int i = 0; i < 5; i++) begin
        rd(A_CNT, v); chk("R8 R9 new ratio after force", v, seqS[i]);
        @(negedge clk);
      end
    end

    // R11 R9 R10 flag set/clear collision in down mode
    wr(A_CTRL, 16 | 2); wr(A_PSC, 0); wr(A_PER, 3); wr(A_EVT, 1); wr(A_FLAG, 1);
    wr(A_CTRL, 16 | 2 | 1);
    wr(A_EVT, 1);
    rd(A_CNT, v);  chk("R9 down reinit", v, 3);
    rd(A_FLAG, v); chk("R9 force sets flag", v, 1);
    chk("R11 irq follows flag", int'(irq), 1);
    chk("R10 pulse after force", int'(updPulse), 1);
    wr(A_FLAG, 1);
    rd(A_FLAG, v); chk("R11 clear", v, 0);
    chk("R11 irq low", int'(irq), 0);
    chk("R10 pulse one cycle", int'(updPulse), 0);
    @(negedge clk);
    @(negedge clk);
    rd(A_CNT, v);  chk("R4 reached zero", v, 0);
    wr(A_FLAG, 1);
    rd(A_FLAG, v); chk("R11 set wins over clear", v, 1);
    chk("R10 pulse on wrap", int'(updPulse), 1);
    rd(A_CNT, v);  chk("R10 new value with pulse", v, 3);
    wr(A_FLAG, 0);
    rd(A_FLAG, v); chk("R11 write zero ignored", v, 1);
    wr(A_CTRL, 2 | 1);
    chk("R11 irq masked", int'(irq), 0);
    rd(A_FLAG, v); chk("R11 flag kept when masked", v, 1);

    // R12 counter write on the wrap cycle
    wr(A_CTRL, 1); wr(A_PSC, 0); wr(A_PER, 3); wr(A_EVT, 1);
    wr(A_FLAG, 1);
    @(negedge clk);
    @(negedge clk);
    rd(A_CNT, v); chk("R12 before write", v, 3);
    wr(A_CNT, 1);
    rd(A_CNT, v); chk("R12 written value", v, 1);
    chk("R12 no pulse", int'(updPulse), 0);
    rd(A_FLAG, v); chk("R12 no flag", v, 0);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    rd(A_CNT, v); chk("R12 wraps later", v, 0);
    chk("R12 pulse later", int'(updPulse), 1);

    // R13 disabled counter holds
    wr(A_CTRL, 0);
    wr(A_FLAG, 1);
    rd(A_CNT, n);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      rd(A_CNT, v); chk("R13 hold", v, n);
      chk("R13 no pulse", int'(updPulse), 0);
    end
    rd(A_FLAG, v); chk("R13 no flag", v, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule